// File: doc/BRIEF.md
# Pad Wakeup Pattern Detector

This block watches one input pad and flags a wakeup when a chosen pattern shows up on it. The pad is taken either from a bus of multiplexed pads or from a bus of dedicated pads. The chosen level can pass through a debounce stage. The detector then looks for a rising edge, a falling edge, any edge, or a level held high or low for a programmed number of clock cycles. A match sets a sticky cause flag. That flag drives the wakeup request until software clears it.

Configuration goes through a plain register port: one write strobe, an address, write data, and read data that follows the address combinationally. A lock bit comes out of reset set and can only be cleared. Once it is cleared, the detector configuration is frozen for good. The cause flag stays clearable after locking. The whole block runs on one clock with a synchronous, active-high reset.

Top module: `pad_wake_detect`

## Requirements
- R1: The register map is: address 0 = lock (bit 0), 1 = enable (bit 0), 2 = control (bits [2:0] mode, bit 3 filter, bit 4 source), 3 = threshold (8 bits), 4 = pad index (6 bits), 5 = cause (bit 0). Reset values are lock 1 and all others 0. Unimplemented bits read 0.
- R2: With source 0 (multiplexed bus), index 0 reads constant 0, index 1 reads constant 1, and index n+2 reads multiplexed pad n. With source 1, index n reads dedicated pad n. An index past the end of the chosen bus reads 0.
- R3: Mode 0 triggers on a rising edge, mode 1 on a falling edge and mode 2 on either edge. With the filter off, a pad change seen at clock edge k sets cause at edge k+1.
- R4: Mode 3 (timed high) and mode 4 (timed low) trigger once the filtered level has sat at the target level for the threshold number of consecutive samples. Leaving the target level restarts the count. The count saturates instead of wrapping, so a held level keeps triggering.
- R5: With the filter bit set, a new pad level is forwarded only after 4 consecutive equal samples. A pulse of 3 samples is dropped.
- R6: Cause is sticky. Writing 0 to bit 0 of address 5 clears it, and writing 1 has no effect. A detection in the same cycle as a clear wins.
- R7: Nothing triggers while enable is 0. Setting enable while the pad is already high does not count as a rising edge.
- R8: Writing 0 to lock clears it, and writing 1 never sets it again. While lock is 0, writes to addresses 1 to 4 are ignored, but cause can still be cleared.
- R9: The wakeup request output equals the cause flag.
- R10: Mode values 5, 6 and 7 never trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the addressed register |
| mux_pads | input | N_MUX_PADS (16) | Multiplexed pad levels |
| ded_pads | input | N_DED_PADS (8) | Dedicated pad levels |
| wake_req | output | 1 | Wakeup request, high while cause is set |

## Verification
The hardest case to reach from the ports is the saturation of the timed-mode counter. A wrapping counter only shows up after more than 256 cycles at the target level. The stimulus therefore holds a pad low under timed-low mode with a threshold of 200 for over 300 cycles, then clears cause. With saturation the detection is still live and cause stays set; with wrapping it would drop. The debounce window and the "no false edge on enable" case are reached by changing the pad while the detector is disabled or for exactly three samples.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int SEL_W      = 6;
    localparam int CNT_W      = 8;
    localparam int STABLE_LEN = 4;
    localparam int MUX_OFS    = 2;

    localparam logic [ADDR_W-1:0] A_LOCK   = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN     = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_THRESH = 3'd3;
    localparam logic [ADDR_W-1:0] A_PADSEL = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 3'd5;

    typedef enum logic [2:0] {
        TRIG_RISE    = 3'd0,
        TRIG_FALL    = 3'd1,
        TRIG_ANY     = 3'd2,
        TRIG_HOLD_HI = 3'd3,
        TRIG_HOLD_LO = 3'd4
    } trig_mode_e;

    typedef struct packed {
        logic             enable;
        logic [2:0]       mode;
        logic             filt_on;
        logic             src_ded;
        logic [SEL_W-1:0] pad_idx;
        logic [CNT_W-1:0] thresh;
    } wake_cfg_t;

    function automatic logic is_timed(logic [2:0] m);
        return (m == TRIG_HOLD_HI) || (m == TRIG_HOLD_LO);
    endfunction

endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
    import pwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hit,
    output wake_cfg_t         cfg,
    output logic              lock,
    output logic              cause,
    output logic [REG_W-1:0]  rdata
);

    logic clr_req;
    assign clr_req = we && (addr == A_CAUSE) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lock  <= 1'b1;
            cfg   <= '0;
            cause <= 1'b0;
        end else begin
            if (we && (addr == A_LOCK) && !wdata[0]) begin
                lock <= 1'b0;
            end
            if (we && lock) begin
                case (addr)
                    A_EN:     cfg.enable  <= wdata[0];
                    A_CTRL: begin
                        cfg.mode    <= wdata[2:0];
                        cfg.filt_on <= wdata[3];
                        cfg.src_ded <= wdata[4];
                    end
                    A_THRESH: cfg.thresh  <= wdata[CNT_W-1:0];
                    A_PADSEL: cfg.pad_idx <= wdata[SEL_W-1:0];
                    default: ;
                endcase
            end
            // a fresh detection outranks a clear in the same cycle
            if (hit) begin
                cause <= 1'b1;
            end else if (clr_req) begin
                cause <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_LOCK:   rdata = REG_W'(lock);
            A_EN:     rdata = REG_W'(cfg.enable);
            A_CTRL:   rdata = REG_W'({cfg.src_ded, cfg.filt_on, cfg.mode});
            A_THRESH: rdata = REG_W'(cfg.thresh);
            A_PADSEL: rdata = REG_W'(cfg.pad_idx);
            A_CAUSE:  rdata = REG_W'(cause);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwd_pad_pick.sv
module pwd_pad_pick
    import pwd_pkg::*;
#(
    parameter int N_MUX = 16,
    parameter int N_DED = 8
) (
    input  logic             src_ded,
    input  logic [SEL_W-1:0] idx,
    input  logic [N_MUX-1:0] mux_pads,
    input  logic [N_DED-1:0] ded_pads,
    output logic             raw
);

    logic mux_val;
    logic ded_val;

    always_comb begin
        mux_val = (idx == SEL_W'(1));
        for (int i = 0; i < N_MUX; i++) begin
            if (idx == SEL_W'(i + MUX_OFS)) begin
                mux_val = mux_pads[i];
            end
        end
    end

    always_comb begin
        ded_val = 1'b0;
        for (int i = 0; i < N_DED; i++) begin
            if (idx == SEL_W'(i)) begin
                ded_val = ded_pads[i];
            end
        end
    end

    assign raw = src_ded ? ded_val : mux_val;

endmodule

// File: rtl/pwd_filter.sv
module pwd_filter
    import pwd_pkg::*;
#(
    parameter int LEN = STABLE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic filt_on,
    output logic level
);

    localparam int RUN_W   = (LEN > 2) ? $clog2(LEN) : 1;
    localparam int RUN_TOP = LEN - 2;

    logic             prev;
    logic [RUN_W-1:0] run;
    logic             same;

    assign same = (raw == prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            run   <= '0;
            level <= 1'b0;
        end else begin
            prev <= raw;
            if (!same) begin
                run <= '0;
            end else if (run != RUN_W'(RUN_TOP)) begin
                run <= run + 1'b1;
            end
            if (!filt_on) begin
                level <= raw;
            end else if (same && (run == RUN_W'(RUN_TOP))) begin
                level <= raw;
            end
        end
    end

endmodule

// File: rtl/pwd_trigger.sv
module pwd_trigger
    import pwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [2:0]       mode,
    input  logic             level,
    input  logic [CNT_W-1:0] thresh,
    output logic             hit
);

    logic             hist;
    logic [CNT_W-1:0] held;
    logic             target;
    logic             at_lvl;
    logic             match;

    assign target = (mode == TRIG_HOLD_HI);
    assign at_lvl = is_timed(mode) && (level == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 1'b0;
            held <= '0;
        end else begin
            // history follows the level even while disabled
            hist <= level;
            if (!enable || !at_lvl) begin
                held <= '0;
            end else if (held != '1) begin
                held <= held + 1'b1;
            end
        end
    end

    always_comb begin
        case (mode)
            TRIG_RISE:    match = level && !hist;
            TRIG_FALL:    match = !level && hist;
            TRIG_ANY:     match = level ^ hist;
            TRIG_HOLD_HI,
            TRIG_HOLD_LO: match = at_lvl &&
                                  (({1'b0, held} + 1'b1) >= {1'b0, thresh});
            default:      match = 1'b0;
        endcase
    end

    assign hit = enable && match;

endmodule

// File: rtl/pad_wake_detect.sv
module pad_wake_detect
    import pwd_pkg::*;
#(
    parameter int N_MUX_PADS = 16,
    parameter int N_DED_PADS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [REG_W-1:0]      cfg_rdata,
    input  logic [N_MUX_PADS-1:0] mux_pads,
    input  logic [N_DED_PADS-1:0] ded_pads,
    output logic                  wake_req
);

    wake_cfg_t cfg_q;
    logic      lock_q;
    logic      cause_q;
    logic      raw_lvl;
    logic      filt_lvl;
    logic      hit;

    pwd_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .hit   (hit),
        .cfg   (cfg_q),
        .lock  (lock_q),
        .cause (cause_q),
        .rdata (cfg_rdata)
    );

    pwd_pad_pick #(
        .N_MUX (N_MUX_PADS),
        .N_DED (N_DED_PADS)
    ) u_pick (
        .src_ded  (cfg_q.src_ded),
        .idx      (cfg_q.pad_idx),
        .mux_pads (mux_pads),
        .ded_pads (ded_pads),
        .raw      (raw_lvl)
    );

    pwd_filter #(
        .LEN (STABLE_LEN)
    ) u_filt (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw_lvl),
        .filt_on (cfg_q.filt_on),
        .level   (filt_lvl)
    );

    pwd_trigger u_trig (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg_q.enable),
        .mode   (cfg_q.mode),
        .level  (filt_lvl),
        .thresh (cfg_q.thresh),
        .hit    (hit)
    );

    assign wake_req = cause_q;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker
    import pwd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              wbit0,
    input logic              lock,
    input logic              cfg_en,
    input logic [2:0]        mode,
    input logic              cause
);

    logic clr_wr;
    assign clr_wr = cfg_we && (cfg_addr == A_CAUSE) && !wbit0;

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !lock |=> !lock);

    assert_locked_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        !lock |=> ($stable(cfg_en) && $stable(mode)));

    assert_cause_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cause && !clr_wr) |=> cause);

    assert_cause_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !cfg_en) |=> !cause);

    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cause) |-> $past(cfg_en));

    assert_bad_mode_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cause) |-> ($past(mode) <= 3'd4));

endmodule

bind pad_wake_detect pwd_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .wbit0    (cfg_wdata[0]),
    .lock     (lock_q),
    .cfg_en   (cfg_q.enable),
    .mode     (cfg_q.mode),
    .cause    (cause_q)
);

// File: tb/pad_wake_detect_tb_top.sv
module pad_wake_detect_tb_top;
    import pwd_pkg::*;

    localparam int NM = 16;
    localparam int ND = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [REG_W-1:0]  cfg_wdata = '0;
    logic [REG_W-1:0]  cfg_rdata;
    logic [NM-1:0]     mux_pads = '0;
    logic [ND-1:0]     ded_pads = '0;
    logic              wake_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pad_wake_detect #(.N_MUX_PADS(NM), .N_DED_PADS(ND)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mux_pads  (mux_pads),
        .ded_pads  (ded_pads),
        .wake_req  (wake_req)
    );

    // {source, index[5:0], mode[2:0], expect on rise, expect on fall}
    localparam logic [11:0] VEC [10] = '{
        {1'b0, 6'd2,  3'd0, 1'b1, 1'b0},
        {1'b0, 6'd9,  3'd1, 1'b0, 1'b1},
        {1'b0, 6'd17, 3'd2, 1'b1, 1'b1},
        {1'b1, 6'd0,  3'd0, 1'b1, 1'b0},
        {1'b1, 6'd7,  3'd2, 1'b1, 1'b1},
        {1'b0, 6'd0,  3'd2, 1'b0, 1'b0},
        {1'b0, 6'd1,  3'd2, 1'b0, 1'b0},
        {1'b0, 6'd3,  3'd6, 1'b0, 1'b0},
        {1'b1, 6'd3,  3'd7, 1'b0, 1'b0},
        {1'b0, 6'd18, 3'd2, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic setup(input logic src, input logic [5:0] idx, input logic [2:0] mode,
                         input logic filt, input logic [7:0] th);
        wr(A_EN, 8'h00);
        wr(A_CTRL, {3'b000, src, filt, mode});
        wr(A_PADSEL, {2'b00, idx});
        wr(A_THRESH, th);
    endtask

    // drive only the selected pad; for constant or missing selections drive every pad
    task automatic drive(input logic src, input logic [5:0] idx, input logic v);
        mux_pads = '0;
        ded_pads = '0;
        if (v) begin
            if (src && idx < ND) ded_pads[idx] = 1'b1;
            else if (!src && idx >= 2 && idx < NM + 2) mux_pads[idx - 2] = 1'b1;
            else begin
                mux_pads = '1;
                ded_pads = '1;
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [REG_W-1:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset values
        rd(A_LOCK, d);   chk("R1 lock reset", d, 8'h01);
        rd(A_EN, d);     chk("R1 enable reset", d, 8'h00);
        rd(A_CTRL, d);   chk("R1 ctrl reset", d, 8'h00);
        rd(A_THRESH, d); chk("R1 thresh reset", d, 8'h00);
        rd(A_PADSEL, d); chk("R1 padsel reset", d, 8'h00);
        rd(A_CAUSE, d);  chk("R1 cause reset", d, 8'h00);
        chk("R9 wake reset", wake_req, 1'b0);
        wr(A_CTRL, 8'hFA);
        rd(A_CTRL, d);   chk("R1 ctrl readback", d, 8'h1A);
        wr(A_PADSEL, 8'hFF);
        rd(A_PADSEL, d); chk("R1 padsel readback", d, 8'h3F);

        // R2 R3 R10 table walk
        for (int v = 0; v < 10; v++) begin
            logic       s;
            logic [5:0] ix;
            logic [2:0] md;
            {s, ix, md} = VEC[v][11:2];
            setup(s, ix, md, 1'b0, 8'd0);
            drive(s, ix, 1'b0);
            tick(2);
            wr(A_CAUSE, 8'h00);
            wr(A_EN, 8'h01);
            tick(3);
            chk($sformatf("R7 no spurious vec%0d", v), wake_req, 1'b0);
            drive(s, ix, 1'b1);
            tick(2);
            chk($sformatf("R2/R3 rise vec%0d", v), wake_req, VEC[v][1]);
            wr(A_CAUSE, 8'h00);
            drive(s, ix, 1'b0);
            tick(2);
            chk($sformatf("R2/R3 fall vec%0d", v), wake_req, VEC[v][0]);
        end

        // R3 exact latency
        setup(1'b0, 6'd2, 3'd0, 1'b0, 8'd0);
        drive(1'b0, 6'd2, 1'b0);
        tick(2);
        wr(A_CAUSE, 8'h00);
        wr(A_EN, 8'h01);
        drive(1'b0, 6'd2, 1'b1);
        tick(1);
        chk("R3 one edge after change", wake_req, 1'b0);
        tick(1);
        chk("R3 two edges after change", wake_req, 1'b1);

        // R6 writing 1 to cause keeps it, writing 0 clears it
        wr(A_EN, 8'h00);
        wr(A_CAUSE, 8'h01);
        chk("R6 write one no effect", wake_req, 1'b1);
        wr(A_CAUSE, 8'h00);
        rd(A_CAUSE, d);
        chk("R6 cleared", d, 8'h00);
        chk("R9 wake follows cause", wake_req, 1'b0);

        // R7 disabled detector ignores edges; enable with pad high is not an edge
        drive(1'b0, 6'd2, 1'b0);
        tick(2);
        chk("R7 disabled ignores fall", wake_req, 1'b0);
        drive(1'b0, 6'd2, 1'b1);
        tick(3);
        chk("R7 disabled ignores rise", wake_req, 1'b0);
        wr(A_EN, 8'h01);
        tick(3);
        chk("R7 enable while high", wake_req, 1'b0);

        // R4 timed high, threshold 5, with restart
        setup(1'b0, 6'd4, 3'd3, 1'b0, 8'd5);
        drive(1'b0, 6'd4, 1'b0);
        tick(2);
        wr(A_CAUSE, 8'h00);
        wr(A_EN, 8'h01);
        drive(1'b0, 6'd4, 1'b1);
        tick(4);
        drive(1'b0, 6'd4, 1'b0);
        tick(1);
        drive(1'b0, 6'd4, 1'b1);
        tick(4);
        drive(1'b0, 6'd4, 1'b0);
        tick(3);
        chk("R4 restart on level loss", wake_req, 1'b0);
        drive(1'b0, 6'd4, 1'b1);
        tick(5);
        chk("R4 before threshold", wake_req, 1'b0);
        tick(1);
        chk("R4 at threshold", wake_req, 1'b1);

        // R4 timed low, threshold 200, saturation
        setup(1'b1, 6'd5, 3'd4, 1'b0, 8'd200);
        drive(1'b1, 6'd5, 1'b0);
        tick(2);
        wr(A_CAUSE, 8'h00);
        wr(A_EN, 8'h01);
        tick(150);
        chk("R4 timed low early", wake_req, 1'b0);
        tick(100);
        chk("R4 timed low fired", wake_req, 1'b1);
        tick(60);
        wr(A_CAUSE, 8'h00);
        chk("R4 saturated still firing", wake_req, 1'b1);
        drive(1'b1, 6'd5, 1'b1);
        tick(2);
        wr(A_CAUSE, 8'h00);
        tick(1);
        chk("R4 stops off level", wake_req, 1'b0);

        // R5 filter
        setup(1'b0, 6'd2, 3'd0, 1'b1, 8'd0);
        drive(1'b0, 6'd2, 1'b0);
        tick(8);
        wr(A_CAUSE, 8'h00);
        wr(A_EN, 8'h01);
        tick(2);
        drive(1'b0, 6'd2, 1'b1);
        tick(3);
        drive(1'b0, 6'd2, 1'b0);
        tick(8);
        chk("R5 three sample glitch dropped", wake_req, 1'b0);
        drive(1'b0, 6'd2, 1'b1);
        tick(4);
        chk("R5 not yet forwarded", wake_req, 1'b0);
        tick(1);
        chk("R5 forwarded after four", wake_req, 1'b1);

        // R8 lock
        wr(A_EN, 8'h00);
        wr(A_LOCK, 8'h00);
        rd(A_LOCK, d);   chk("R8 lock cleared", d, 8'h00);
        wr(A_LOCK, 8'h01);
        rd(A_LOCK, d);   chk("R8 lock stays clear", d, 8'h00);
        wr(A_EN, 8'h01);
        rd(A_EN, d);     chk("R8 enable frozen", d, 8'h00);
        wr(A_CTRL, 8'h04);
        rd(A_CTRL, d);   chk("R8 ctrl frozen", d, 8'h08);
        wr(A_THRESH, 8'h33);
        rd(A_THRESH, d); chk("R8 thresh frozen", d, 8'h00);
        wr(A_PADSEL, 8'h07);
        rd(A_PADSEL, d); chk("R8 padsel frozen", d, 8'h02);
        wr(A_CAUSE, 8'h00);
        chk("R8 cause clear while locked", wake_req, 1'b0);
        drive(1'b0, 6'd2, 1'b0);
        tick(6);
        drive(1'b0, 6'd2, 1'b1);
        tick(6);
        chk("R8 still disabled", wake_req, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule